// File: doc/BRIEF.md
# Multi-Channel Prescaled Frequency Meter

This block measures the rate of several independent pulse inputs that share no timing relationship with the system clock. It runs in repeated measurement frames. For each channel, a frame takes one of two forms. In gated mode, an optional divider first slows the input by 1, 2 or 4. A counter clocked by the divided signal then runs for a window set by the system clock. That window is longer by the same factor as the divider, so the result is always the number of input edges in `gate_len` reference cycles. In period mode, the block counts reference cycles between two successive rising input edges. Slow signals are measured this way.

A gated count does not cross into the system domain while it is still moving. Each frame first closes the gates. The block then waits a fixed settling interval. Only after that does it take the Gray-coded counts, which have passed through two synchronizer flops. Each channel selects its mode by itself. A gated result below `lo_thr` puts that channel into period mode for the next frame. A period result below `hi_thr` puts it back into gated mode. The results leave on a valid/ready stream, one beat per channel, in ascending channel order.

Back-pressure rules: once `res_valid` is high, it stays high and every payload field stays stable until a cycle with `res_ready` high. No new frame starts until the last channel's beat has been accepted. In gated mode, the divided input period must be short compared to `SETTLE` reference cycles.

Top module: `freq_meter`

## Requirements
- R1: While reset is held, and after it is released, `res_valid` stays low until a frame completes. Every channel starts in gated mode (`res_mode` = 0).
- R2: In gated mode with prescale code 0, `res_count` equals the number of input rising edges during `gate_len` reference cycles, within ±2.
- R3: The prescale code (0 means ÷1, 1 means ÷2, 2 means ÷4; 3 is treated as 2) is latched at frame start and reported on `res_psc`. The gate lasts `gate_len << code` cycles, so the count keeps the scale of R2.
- R4: Each frame emits exactly NCH beats, with `res_chan` running 0, 1, …, NCH-1 in order.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid` and all payload fields stay unchanged in the next cycle.
- R6: If a gated result is below `lo_thr`, the channel's next result is in period mode (`res_mode` = 1).
- R7: In period mode, `res_count` is the number of reference cycles between two successive rising input edges, within ±1. The frame does not end before that second edge or the timeout.
- R8: If a period-mode channel sees no second edge before `per_timeout` reference cycles, its result has `res_nosig` = 1 and `res_count` = 0, and the channel stays in period mode.
- R9: If a valid period result is below `hi_thr`, the channel's next result is in gated mode.
- R10: Counts saturate at all ones instead of wrapping. A saturated result sets `res_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | NCH | Asynchronous pulse inputs, one bit per channel |
| psc_sel | input | 2*NCH | Prescale code per channel, two bits each, channel 0 in the low bits |
| gate_len | input | CW | Base gate length in reference cycles |
| per_timeout | input | CW+2 | Frame cycle limit for period-mode channels |
| lo_thr | input | CW | Gated count below which a channel switches to period mode |
| hi_thr | input | CW | Period count below which a channel switches to gated mode |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Consumer accepts the beat |
| res_chan | output | clog2(NCH) | Channel index of the beat |
| res_count | output | CW | Raw edge count or period count |
| res_mode | output | 1 | 0 = gated count, 1 = period count |
| res_psc | output | 2 | Prescale code used in this frame |
| res_ovf | output | 1 | Count saturated |
| res_nosig | output | 1 | Period mode timed out with no second edge |

## Verification
On every cycle, the assertions check the stream's stall behaviour and the ascending channel order. They also check that a no-signal beat carries a zero count and the period mode, that both counters hold at full scale, and that a completed period measurement stays frozen. The scenarios alone must show whether the counts are accurate against the input rates and whether the gate stretches with the divider. They also show the mode switching in both directions across frames, the timeout path, and saturation under a very fast input. These depend on asynchronous stimulus and on history across frames, which a short property cannot capture.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_EMIT   = 2'd3
  } fm_state_e;

  localparam logic [1:0] PSC_DIV4 = 2'd2;
endpackage

// File: rtl/fm_prescale_counter.sv
module fm_prescale_counter #(
  parameter int CW = 24
) (
  input  logic          rst_n,
  input  logic          sig,
  input  logic [1:0]    psc,
  input  logic          gate,
  output logic [CW-1:0] cnt_gray
);
  logic [1:0]    div_q;
  logic          pclk;
  logic [2:0]    gsync;
  logic [CW-1:0] cnt_q, cnt_nx;

  always_ff @(posedge sig or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 2'd1;

  always_comb
    case (psc)
      2'd0:    pclk = sig;
      2'd1:    pclk = div_q[0];
      default: pclk = div_q[1];
    endcase

  always_comb begin
    cnt_nx = cnt_q;
    if (gsync[1] && !gsync[2])            cnt_nx = '0;
    else if (gsync[1] && (cnt_q != '1))   cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      gsync    <= '0;
      cnt_q    <= '0;
      cnt_gray <= '0;
    end else begin
      gsync    <= {gsync[1:0], gate};
      cnt_q    <= cnt_nx;
      cnt_gray <= cnt_nx ^ (cnt_nx >> 1);
    end

  // R10: a running gated count that reached full scale never wraps
  a_r10_gated_sat: assert property (@(posedge pclk) disable iff (!rst_n)
    (gsync[1] && gsync[2] && (cnt_q == '1)) |=> (cnt_q == '1));
endmodule

// File: rtl/fm_gray_sync.sv
module fm_gray_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end

  always_comb begin
    bin_out[W-1] = s2[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ s2[i];
  end
endmodule

// File: rtl/fm_period_counter.sv
module fm_period_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sig,
  output logic          done,
  output logic [CW-1:0] cnt
);
  typedef enum logic [1:0] {P_IDLE, P_RUN, P_DONE} ph_e;
  ph_e        ph;
  logic [2:0] s;
  logic       rise;

  assign rise = s[1] && !s[2];
  assign done = (ph == P_DONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s   <= '0;
      ph  <= P_IDLE;
      cnt <= '0;
    end else begin
      s <= {s[1:0], sig};
      if (!en) begin
        ph  <= P_IDLE;
        cnt <= '0;
      end else begin
        case (ph)
          P_IDLE: if (rise) begin
            ph  <= P_RUN;
            cnt <= '0;
          end
          P_RUN: begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (rise) ph <= P_DONE;
          end
          default: ;
        endcase
      end
    end

  // R7: a finished period result stays frozen while measurement is enabled
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done) |=> (!en || (done && $stable(cnt))));

  // R10: the period counter holds at full scale
  a_r10_period_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (ph == P_RUN) && (cnt == '1)) |=> (!en || (cnt == '1)));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CW     = 24,
  parameter int SETTLE = 32,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TW    = CW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   sig_in,
  input  logic [2*NCH-1:0] psc_sel,
  input  logic [CW-1:0]    gate_len,
  input  logic [TW-1:0]    per_timeout,
  input  logic [CW-1:0]    lo_thr,
  input  logic [CW-1:0]    hi_thr,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CHW-1:0]   res_chan,
  output logic [CW-1:0]    res_count,
  output logic             res_mode,
  output logic [1:0]       res_psc,
  output logic             res_ovf,
  output logic             res_nosig
);
  localparam int SW = $clog2(SETTLE + 1);

  fm_state_e      st;
  logic [TW-1:0]  timer, gate_end;
  logic [SW-1:0]  set_cnt;
  logic [CHW-1:0] idx;
  logic [NCH-1:0] mode_q, gate_q, pdone, per_en;
  logic [NCH-1:0] r_mode, r_ovf, r_nosig;
  logic [1:0]     psc_q    [NCH];
  logic [CW-1:0]  fgray    [NCH];
  logic [CW-1:0]  fcnt     [NCH];
  logic [CW-1:0]  pcnt     [NCH];
  logic [CW-1:0]  r_cnt    [NCH];
  logic [TW-1:0]  gate_lim [NCH];
  logic           per_ok, run_exit;

  assign gate_end = {2'b00, gate_len} << 2;
  assign per_ok   = (&(pdone | ~mode_q)) || (timer >= per_timeout);
  assign run_exit = (timer >= gate_end) && per_ok;

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    assign gate_lim[g] = {2'b00, gate_len} << psc_q[g];
    assign per_en[g]   = (st == ST_RUN) && mode_q[g];

    fm_prescale_counter #(.CW(CW)) u_fast (
      .rst_n(rst_n), .sig(sig_in[g]), .psc(psc_q[g]),
      .gate(gate_q[g]), .cnt_gray(fgray[g]));

    fm_gray_sync #(.W(CW)) u_xfer (
      .clk(clk), .rst_n(rst_n), .gray_in(fgray[g]), .bin_out(fcnt[g]));

    fm_period_counter #(.CW(CW)) u_per (
      .clk(clk), .rst_n(rst_n), .en(per_en[g]), .sig(sig_in[g]),
      .done(pdone[g]), .cnt(pcnt[g]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gate_q <= '0;
    else
      for (int i = 0; i < NCH; i++)
        gate_q[i] <= (st == ST_RUN) && !mode_q[i] && (timer < gate_lim[i]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_LOAD;
      timer   <= '0;
      set_cnt <= '0;
      idx     <= '0;
      mode_q  <= '0;
      r_mode  <= '0;
      r_ovf   <= '0;
      r_nosig <= '0;
      for (int i = 0; i < NCH; i++) begin
        psc_q[i] <= '0;
        r_cnt[i] <= '0;
      end
    end else begin
      case (st)
        ST_LOAD: begin
          for (int i = 0; i < NCH; i++)
            psc_q[i] <= (psc_sel[2*i +: 2] == 2'd3) ? PSC_DIV4 : psc_sel[2*i +: 2];
          timer <= '0;
          st    <= ST_RUN;
        end
        ST_RUN: begin
          timer <= timer + 1'b1;
          if (run_exit) begin
            st      <= ST_SETTLE;
            set_cnt <= '0;
            for (int i = 0; i < NCH; i++)
              if (mode_q[i]) begin
                r_cnt[i]   <= pdone[i] ? pcnt[i] : '0;
                r_nosig[i] <= !pdone[i];
                r_ovf[i]   <= pdone[i] && (pcnt[i] == '1);
              end
          end
        end
        ST_SETTLE: begin
          set_cnt <= set_cnt + 1'b1;
          if (set_cnt == SW'(SETTLE - 1)) begin
            st  <= ST_EMIT;
            idx <= '0;
            for (int i = 0; i < NCH; i++) begin
              r_mode[i] <= mode_q[i];
              if (!mode_q[i]) begin
                r_cnt[i]   <= fcnt[i];
                r_ovf[i]   <= (fcnt[i] == '1);
                r_nosig[i] <= 1'b0;
                mode_q[i]  <= (fcnt[i] < lo_thr);
              end else begin
                mode_q[i]  <= r_nosig[i] || (r_cnt[i] >= hi_thr);
              end
            end
          end
        end
        default: begin
          if (res_ready) begin
            if (idx == CHW'(NCH - 1)) st <= ST_LOAD;
            else                      idx <= idx + 1'b1;
          end
        end
      endcase
    end

  assign res_valid = (st == ST_EMIT);
  assign res_chan  = idx;
  assign res_count = r_cnt[idx];
  assign res_mode  = r_mode[idx];
  assign res_psc   = psc_q[idx];
  assign res_ovf   = r_ovf[idx];
  assign res_nosig = r_nosig[idx];

  // R5: a stalled beat keeps valid and its whole payload
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_chan) && $stable(res_count)
      && $stable(res_mode) && $stable(res_psc) && $stable(res_ovf) && $stable(res_nosig)));

  // R4: an accepted beat that is not the last is followed by the next channel
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && (res_chan != CHW'(NCH - 1)))
      |=> (res_valid && (res_chan == $past(res_chan) + 1'b1)));

  // R8: a no-signal beat carries zero and the period mode
  a_r8_nosig_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nosig) |-> ((res_count == '0) && res_mode));

  // R4: channel index stays in range
  a_r4_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_chan < CHW'(NCH)));
endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  localparam int NCH = 5;
  localparam int CW  = 12;
  localparam int TW  = CW + 2;
  localparam int MAXC = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  wire  [NCH-1:0]  sig;
  logic [2*NCH-1:0] psc_sel;
  logic [CW-1:0]   gate_len, lo_thr, hi_thr;
  logic [TW-1:0]   per_timeout;
  logic            res_valid, res_ready, res_mode, res_ovf, res_nosig;
  logic [2:0]      res_chan;
  logic [CW-1:0]   res_count;
  logic [1:0]      res_psc;

  real half_ns [NCH];
  int  checks = 0, errors = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : gen_src
    logic s = 1'b0;
    initial forever begin
      if (half_ns[g] <= 0.0) #1;
      else begin
        #(half_ns[g]);
        s = ~s;
      end
    end
    assign sig[g] = s;
  end

  freq_meter #(.NCH(NCH), .CW(CW), .SETTLE(32)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .psc_sel(psc_sel),
    .gate_len(gate_len), .per_timeout(per_timeout), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
    .res_count(res_count), .res_mode(res_mode), .res_psc(res_psc),
    .res_ovf(res_ovf), .res_nosig(res_nosig));

  // behavioural model state
  real per_ns   [NCH];
  real m_per    [NCH];
  int  psc_code [NCH];
  int  m_psc    [NCH];
  int  m_gl;
  bit  mmode    [NCH];
  int  exp_ch = 0, fr = 0, cyc = 0;
  bit  hold_pend = 0;
  int  h_chan, h_cnt, h_mode, h_psc, h_ovf, h_nos;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_inputs();
    for (int i = 0; i < NCH; i++) begin
      half_ns[i] = per_ns[i] / 2.0;
      psc_sel[2*i +: 2] = 2'(psc_code[i]);
    end
  endtask

  task automatic snapshot();
    for (int i = 0; i < NCH; i++) begin
      m_per[i] = per_ns[i];
      m_psc[i] = psc_code[i];
    end
    m_gl = int'(gate_len);
  endtask

  task automatic accept();
    int e;
    int c;
    c = int'(res_count);
    check(int'(res_chan) == exp_ch, "R4", "channel order", int'(res_chan), exp_ch);
    check(res_mode == mmode[exp_ch], (mmode[exp_ch] ? "R6" : "R9"), "mode bit", int'(res_mode), int'(mmode[exp_ch]));
    check(int'(res_psc) == m_psc[exp_ch], "R3", "prescale tag", int'(res_psc), m_psc[exp_ch]);
    if (!mmode[exp_ch]) begin
      e = (m_per[exp_ch] > 0.0) ? int'(m_gl * 8.0 / m_per[exp_ch]) : 0;
      if (e > MAXC) e = MAXC;
      check((c >= e - 2) && (c <= e + 2), (m_psc[exp_ch] == 0) ? "R2" : "R3", "gated count", c, e);
      check(res_ovf == (e == MAXC), "R10", "overflow flag", int'(res_ovf), int'(e == MAXC));
      check(!res_nosig, "R8", "nosig in gated", int'(res_nosig), 0);
      mmode[exp_ch] = (c < int'(lo_thr));
    end else if (m_per[exp_ch] <= 0.0) begin
      check(res_nosig && (c == 0), "R8", "timeout result", c, 0);
      mmode[exp_ch] = 1'b1;
    end else begin
      e = int'(m_per[exp_ch] / 8.0);
      check((c >= e - 1) && (c <= e + 1) && !res_nosig, "R7", "period count", c, e);
      mmode[exp_ch] = !(c < int'(hi_thr));
    end
    if (exp_ch == 0) begin
      if (fr == 1) per_ns[3] = 160.0;
      if (fr == 3) begin
        gate_len = 12'd1000;
        per_ns[0] = 1.6;
        per_ns[4] = 80.0;
      end
      apply_inputs();
    end
    if (exp_ch == NCH - 1) begin
      exp_ch = 0;
      fr++;
      snapshot();
    end else exp_ch++;
  endtask

  initial begin
    rst_n = 1'b0;
    res_ready = 1'b0;
    gate_len = 12'd100;
    lo_thr = 12'd20;
    hi_thr = 12'd50;
    per_timeout = 14'd4000;
    per_ns   = '{20.0, 5.0, 4.0, 400.0, 0.0};
    psc_code = '{0, 1, 2, 0, 0};
    foreach (mmode[i]) mmode[i] = 1'b0;
    apply_inputs();
    snapshot();
    repeat (5) @(negedge clk);
    check(!res_valid, "R1", "valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid, "R1", "valid after reset", int'(res_valid), 0);
    while (fr < 5 && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      if (hold_pend)
        check(res_valid && int'(res_chan) == h_chan && int'(res_count) == h_cnt &&
              int'(res_mode) == h_mode && int'(res_psc) == h_psc &&
              int'(res_ovf) == h_ovf && int'(res_nosig) == h_nos,
              "R5", "stalled beat changed", int'(res_count), h_cnt);
      res_ready = (($urandom % 4) != 0);
      hold_pend = res_valid && !res_ready;
      h_chan = int'(res_chan); h_cnt = int'(res_count); h_mode = int'(res_mode);
      h_psc = int'(res_psc); h_ovf = int'(res_ovf); h_nos = int'(res_nosig);
      if (res_valid && res_ready) accept();
    end
    if (cyc >= 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual frame %0d expected %0d", fr, 5);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule